// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

A register-mapped event timer built around one free-running 32-bit main counter and a small set of comparator channels (three by default). Each channel compares its own match value with the counter. On a match it latches a status bit and can raise an interrupt. A channel either fires once, or reloads itself by a programmed period so that it fires at a fixed rate. Software reaches every register through a single-cycle 32-bit port: a write takes effect on the clock edge where `bus_wr` is high, and read data is returned combinationally for the current address.

Each channel chooses one of 32 interrupt lines through a 5-bit route field. It can signal either as a one-cycle pulse or as a level that is held until software clears the status bit. A global legacy mode overrides the route fields of the first two channels and sends them to lines 0 and 8. Periodic channels are programmed with an arm-then-two-writes sequence. This sequence lets software set the first match point and the period through one comparator address.

Register map (byte offsets): 0x000 capabilities, 0x004 tick period, 0x010 global control, 0x020 status, 0x0F0 main counter; for channel n, 0x100+0x20·n control, 0x104+0x20·n route mask, 0x108+0x20·n comparator.

Top module: `evt_timer`

## Requirements
- R1: The capability word at 0x000 reads vendor ID in bits 31:16, legacy-capable flag 1 in bit 15, counter-size flag 0 in bit 13, channel count minus one in bits 12:8 and revision in bits 7:0. Offset 0x004 reads the nonzero tick period in femtoseconds. Offset 0x104+0x20·n reads the channel's route mask.
- R2: While global enable (bit 0 of 0x010) is clear, the main counter holds its value, and a write to 0x0F0 loads it.
- R3: While global enable is set, the counter advances by one per clock, and writes to 0x0F0 are ignored.
- R4: Channel control bits are: bit 1 level type, bit 2 interrupt enable, bit 3 periodic, bit 4 periodic-capable (read-only 1), bit 6 value-set, bit 8 force-32, bits 13:9 route. Writing control with bit 6 set arms value-set, which reads back as 1. In a periodic channel, the next comparator write then sets the match value and the one after sets the period, and bit 6 reads 0 again. On each match of a periodic channel, the comparator advances by the period.
- R5: A one-shot channel (bit 3 clear) fires once and keeps its comparator value after the match.
- R6: In edge mode (bit 1 clear) with interrupt enable set, a match yields a one-cycle high on the routed line. The pulse is first seen while the counter reads the match value plus one.
- R7: In level mode with interrupt enable set, the routed line stays high while the channel's status bit is set, even after the counter stops.
- R8: The status register at 0x020 holds bit n for channel n. Writing 1 clears a bit; writing 0 leaves it unchanged.
- R9: A match sets the channel's status bit even when its interrupt enable is clear, and in that case no line is driven.
- R10: With legacy mode (bit 1 of 0x010) set, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold.
- R11: Outside legacy mode, a channel drives the line numbered by its route field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (12) | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_line | output | 32 | Interrupt lines, one bit per line number |

## Verification
The hardest state to reach is a periodic channel that reloads repeatedly after the two-write value-set handshake. Reaching it needs the arm write, two comparator writes in the right order and a running counter, and each reload is visible only as a single-cycle pulse. The bench loads the counter while the timer is disabled, so every match point is known in advance. It then watches the routed line on every falling edge and records the counter value at each pulse; that value must equal the match point plus one, then plus one period, and so on. Legacy override is reached the same way: route fields point at lines that must stay silent while lines 0 and 8 fire.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int          NCH       = 3,
  parameter int          AW        = 12,
  parameter logic [15:0] VENDOR_ID = 16'h5A17,
  parameter logic [7:0]  REV_ID    = 8'h02,
  parameter logic [31:0] TICK_FS   = 32'd10_000_000,
  parameter logic [31:0] LINE_MASK = 32'h00F0_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [31:0]   irq_line
);
  localparam logic [AW-1:0] A_CAPS = AW'(12'h000);
  localparam logic [AW-1:0] A_TICK = AW'(12'h004);
  localparam logic [AW-1:0] A_GCTL = AW'(12'h010);
  localparam logic [AW-1:0] A_STS  = AW'(12'h020);
  localparam logic [AW-1:0] A_CNT  = AW'(12'h0F0);
  localparam logic [31:0]   CAPS   = {VENDOR_ID, 1'b1, 1'b0, 1'b0, 5'(NCH - 1), REV_ID};

  logic                   run_q, leg_q;
  logic [31:0]            cnt_q;
  logic [NCH-1:0]         sts_v, hit_v, per_v;
  logic [NCH-1:0][31:0]   cmp_v, prd_v, ctl_v, irq_v;

  wire wr_gctl = bus_wr && bus_addr == A_GCTL;
  wire wr_sts  = bus_wr && bus_addr == A_STS;
  wire wr_cnt  = bus_wr && bus_addr == A_CNT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (wr_gctl) begin
        run_q <= bus_wdata[0];
        leg_q <= bus_wdata[1];
      end
      if (run_q) cnt_q <= cnt_q + 32'd1;
      else if (wr_cnt) cnt_q <= bus_wdata;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] A_CTL = AW'(256 + 32 * i);
    localparam logic [AW-1:0] A_CMP = AW'(264 + 32 * i);
    logic        ie, per, lvl, f32, vs, vs2, sts, pls;
    logic [4:0]  rte;
    logic [31:0] cmp, prd;
    wire wr_ctl = bus_wr && bus_addr == A_CTL;
    wire wr_cmp = bus_wr && bus_addr == A_CMP;
    wire hit    = run_q && cnt_q == cmp;
    wire [4:0] dest = (leg_q && i < 2) ? ((i == 0) ? 5'd0 : 5'd8) : rte;
    wire fire   = lvl ? (sts && ie) : pls;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        {ie, per, lvl, f32, vs, vs2, sts, pls} <= '0;
        rte <= '0;
        cmp <= '1;
        prd <= '0;
      end else begin
        if (wr_ctl) begin
          lvl <= bus_wdata[1];
          ie  <= bus_wdata[2];
          per <= bus_wdata[3];
          f32 <= bus_wdata[8];
          rte <= bus_wdata[13:9];
          if (bus_wdata[6]) begin
            vs  <= 1'b1;
            vs2 <= 1'b0;
          end
        end
        if (wr_cmp) begin
          if (per && vs) begin
            if (!vs2) begin
              cmp <= bus_wdata;
              vs2 <= 1'b1;
            end else begin
              prd <= bus_wdata;
              vs  <= 1'b0;
              vs2 <= 1'b0;
            end
          end else cmp <= bus_wdata;
        end else if (hit && per) cmp <= cmp + prd;
        if (hit) sts <= 1'b1;
        else if (wr_sts && bus_wdata[i]) sts <= 1'b0;
        pls <= hit && ie && !lvl;
      end
    end

    assign sts_v[i] = sts;
    assign hit_v[i] = hit;
    assign per_v[i] = per;
    assign cmp_v[i] = cmp;
    assign prd_v[i] = prd;
    assign ctl_v[i] = {16'h0, 2'b00, rte, f32, 1'b0, vs, 1'b0, 1'b1, per, ie, lvl, 1'b0};
    assign irq_v[i] = fire ? (32'd1 << dest) : 32'd0;
  end

  always_comb begin
    irq_line = '0;
    for (int i = 0; i < NCH; i++) irq_line |= irq_v[i];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CAPS:  bus_rdata = CAPS;
      A_TICK:  bus_rdata = TICK_FS;
      A_GCTL:  bus_rdata = {30'd0, leg_q, run_q};
      A_STS:   bus_rdata = 32'(sts_v);
      A_CNT:   bus_rdata = cnt_q;
      default: bus_rdata = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(256 + 32 * i)) bus_rdata = ctl_v[i];
      if (bus_addr == AW'(260 + 32 * i)) bus_rdata = LINE_MASK;
      if (bus_addr == AW'(264 + 32 * i)) bus_rdata = cmp_v[i];
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int NCH = 3,
  parameter int AW  = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run,
  input logic                 bus_wr,
  input logic [AW-1:0]        bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          cnt,
  input logic [NCH-1:0]       sts,
  input logic [NCH-1:0]       hit,
  input logic [NCH-1:0]       per,
  input logic [NCH-1:0][31:0] cmp,
  input logic [NCH-1:0][31:0] prd
);
  wire cnt_wr = bus_wr && bus_addr == AW'(12'h0F0);
  wire sts_wr = bus_wr && bus_addr == AW'(12'h020);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + 32'd1);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    wire cmp_wr = bus_wr && bus_addr == AW'(264 + 32 * i);

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && per[i] && !cmp_wr) |=> cmp[i] == $past(cmp[i]) + $past(prd[i]));

    p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && !per[i] && !cmp_wr) |=> $stable(cmp[i]));

    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && !(sts_wr && bus_wdata[i])) |=> sts[i]);

    p_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> sts[i]);
  end
endmodule

bind evt_timer evt_timer_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt(cnt_q), .sts(sts_v), .hit(hit_v), .per(per_v),
  .cmp(cmp_v), .prd(prd_v)
);

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [11:0] bus_addr = 12'h0F0;
  logic [31:0] bus_wdata = 0, bus_rdata, irq_line;
  int checks = 0, errors = 0;

  localparam logic [31:0] IE = 32'h4, LVL = 32'h2, PER = 32'h8, VS = 32'h40;

  evt_timer uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_line(irq_line));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_addr = 12'h0F0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 12'h0F0;
  endtask

  task automatic wait_line(input int line, input int limit, output logic [31:0] cv,
                           output logic [31:0] vec);
    cv = 32'hFFFF_FFFF; vec = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      #1;
      if (irq_line[line]) begin
        cv = bus_rdata; vec = irq_line;
        break;
      end
    end
  endtask

  task automatic restart(input logic [31:0] start);
    wr(12'h010, 0);
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h0F0, start);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h000, d); check("R1 caps", d, 32'h5A17_8202);
    rd(12'h004, d); check("R1 tick period", d, 32'd10_000_000);
    rd(12'h124, d); check("R1 route mask", d, 32'h00F0_0000);
    rd(12'h020, d); check("R8 status after reset", d, 0);
    check("R6 lines after reset", irq_line, 0);
    repeat (5) @(negedge clk);
    rd(12'h0F0, d); check("R2 counter idle", d, 0);
  endtask

  task automatic t_counter;
    logic [31:0] a, b;
    wr(12'h0F0, 32'h1234);
    rd(12'h0F0, a); check("R2 counter load", a, 32'h1234);
    wr(12'h010, 1);
    rd(12'h0F0, a); check("R3 first tick", a, 32'h1235);
    rd(12'h0F0, b); check("R3 step of one", b - a, 1);
    wr(12'h0F0, 0);
    rd(12'h0F0, a); check("R3 write ignored while running", 32'(a > 32'h1236), 1);
  endtask

  task automatic t_periodic;
    logic [31:0] d, cv, vec;
    restart(0);
    wr(12'h100, IE | PER | VS | (32'd22 << 9));
    rd(12'h100, d); check("R4 value-set armed", d[6], 1);
    check("R4 periodic-capable flag", d[4], 1);
    wr(12'h108, 20);
    wr(12'h108, 10);
    rd(12'h100, d); check("R4 value-set cleared", d[6], 0);
    rd(12'h108, d); check("R4 match value", d, 20);
    wr(12'h010, 1);
    for (int k = 0; k < 3; k++) begin
      wait_line(22, 40, cv, vec);
      check("R4 R6 R11 periodic pulse time", cv, 32'(21 + 10 * k));
      @(negedge clk); #1;
      check("R6 pulse width", irq_line[22], 0);
    end
    rd(12'h020, d); check("R9 status ch0", d[0], 1);
    wr(12'h010, 0);
    wr(12'h100, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] d, cv, vec;
    logic again;
    restart(0);
    wr(12'h120, IE | (32'd20 << 9));
    wr(12'h128, 15);
    wr(12'h010, 1);
    wait_line(20, 50, cv, vec);
    check("R6 R11 one-shot pulse time", cv, 16);
    @(negedge clk); #1;
    check("R6 pulse width", irq_line[20], 0);
    again = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); #1;
      if (irq_line[20]) again = 1;
    end
    check("R5 no second fire", again, 0);
    rd(12'h128, d); check("R5 comparator kept", d, 15);
    rd(12'h020, d); check("R5 status ch1", d[1], 1);
    wr(12'h010, 0);
    wr(12'h120, 0);
  endtask

  task automatic t_level;
    logic [31:0] d, cv, vec;
    restart(0);
    wr(12'h140, IE | LVL | (32'd23 << 9));
    wr(12'h148, 5);
    wr(12'h010, 1);
    wait_line(23, 30, cv, vec);
    check("R7 level asserted", vec[23], 1);
    wr(12'h010, 0);
    repeat (4) @(negedge clk);
    #1 check("R7 level held", irq_line[23], 1);
    wr(12'h020, 32'h3);
    #1 check("R8 zero bit leaves status", irq_line[23], 1);
    rd(12'h020, d); check("R8 status ch2 kept", d[2], 1);
    wr(12'h020, 32'h4);
    #1 check("R8 one clears line", irq_line[23], 0);
    rd(12'h020, d); check("R8 status ch2 cleared", d[2], 0);
  endtask

  task automatic t_masked;
    logic [31:0] d;
    logic seen;
    restart(0);
    wr(12'h140, LVL | (32'd23 << 9));
    wr(12'h148, 3);
    wr(12'h010, 1);
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #1;
      if (irq_line != 0) seen = 1;
    end
    check("R9 no line without enable", seen, 0);
    wr(12'h010, 0);
    rd(12'h020, d); check("R9 status set without enable", d[2], 1);
  endtask

  task automatic t_legacy;
    logic [31:0] d, cv, vec;
    restart(0);
    wr(12'h100, IE | (32'd22 << 9));
    wr(12'h108, 8);
    wr(12'h120, IE | LVL | (32'd20 << 9));
    wr(12'h128, 12);
    wr(12'h010, 3);
    wait_line(0, 30, cv, vec);
    check("R10 channel 0 on line 0", cv, 9);
    check("R10 route field of channel 0 unused", vec[22], 0);
    wait_line(8, 30, cv, vec);
    check("R10 channel 1 on line 8", cv, 13);
    check("R10 route field of channel 1 unused", vec[20], 0);
    rd(12'h010, d); check("R10 control readback", d, 3);
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_counter();
    t_periodic();
    t_oneshot();
    t_level();
    t_masked();
    t_legacy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule